// File: doc/BRIEF.md
# Synchronous-RAM Branch History Table

This block predicts conditional branch direction with a table of 2-bit saturating counters. The table lives in a behavioural synchronous RAM with two registered read ports and one write port, the kind of storage that maps onto on-chip block memory. No read can return data in the cycle its address is presented. The fetch side presents a lookup address and gets a valid flag and a taken flag in the next cycle. The execute side reports each resolved branch with its address and outcome. The block reads the stored entry, trains it, and writes it back one cycle later.

The RAM only shows a write on a read issued after the write edge. To hide this, the block keeps the most recent write-back and its index in an auxiliary register. The prediction output then takes the entry from one of three places:

- the write-back being formed in the current cycle;
- the auxiliary register;
- the RAM read data.

The choice depends on how long ago the matching update arrived. The same auxiliary copy lets a second update to the same entry in the next cycle build on the first one.

After reset, an internal sweep clears the table one entry per cycle. While the sweep runs, lookups report invalid and updates are dropped.

Top module: `bht_sync_ram`

## Requirements
- R1: The table index is the address field `addr[ALIGN_LSB +: log2(NUM_ENTRIES)]`, for both lookups and updates. Addresses that agree in that field share an entry, whatever their other bits hold.
- R2: Reset clears the table. For the first NUM_ENTRIES rising edges after reset is released, `pred_valid_o` stays 0 and update strobes have no effect. The sweep writes and the update write-backs never use the write port in the same cycle. Once the sweep ends, every entry reads invalid.
- R3: A lookup address is sampled on a rising edge. Its prediction is on the outputs for the whole following cycle. The prediction reflects every accepted update sampled on that same edge or earlier.
- R4: An update to an invalid entry makes it valid. Its counter becomes 2 if the branch was taken and 1 if not.
- R5: An update to a valid entry raises the counter by one on taken, stopping at 3. It lowers the counter by one on not-taken, stopping at 0.
- R6: `pred_valid_o` is the entry's valid bit. `pred_taken_o` is 1 only when the entry is valid and bit 1 of its counter is 1.
- R7: An update sampled on the same edge as a lookup of the same index is reflected by taking the value from the update logic.
- R8: An update sampled one edge before the lookup is reflected from the auxiliary register. That register holds the most recent write-back and its index from the cycle after the write.
- R9: An update sampled two or more edges before the lookup is reflected by the RAM read data.
- R10: Two updates to the same index on consecutive edges both take effect, in order.
- R11: Each accepted update is written back exactly one cycle after its strobe, at the index it was sampled with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_addr_i | input | ADDR_W | Fetch address to predict, presented one cycle ahead of the fetch |
| pred_valid_o | output | 1 | The looked-up entry holds trained history |
| pred_taken_o | output | 1 | Predicted direction: 1 means taken |
| upd_valid_i | input | 1 | Strobe for one resolved branch |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome: 1 means taken |

## Verification
The bound checker watches the write port on every cycle:

- sweep and update writes never collide;
- sweep writes carry a cleared entry;
- nothing is written back or predicted while the sweep runs;
- each write-back lands one cycle after its strobe, at the strobe's index, with the valid bit set;
- the auxiliary register follows the write port;
- back-to-back write-backs to one index differ by at most one counter step.

Only the bench's scenarios can show that the forwarding picks the freshest copy. It compares the predictions against a reference table that is updated at once, and it runs lookups the same edge, one edge, two edges and many edges after an update. The same scenarios show that index aliasing, weak initial training and saturation at both ends give the right direction.

// File: rtl/bht_sync_pkg.sv
package bht_sync_pkg;

   // One table entry: valid flag above a 2-bit saturating counter.
   typedef struct packed {
      logic       vld;
      logic [1:0] ctr;
   } bht_entry_t;

   localparam int unsigned BHT_ENTRY_W = $bits(bht_entry_t);

   // Which copy of an entry feeds the prediction output.
   typedef enum logic [1:0] {
      SRC_RAM = 2'd0,
      SRC_AUX = 2'd1,
      SRC_UPD = 2'd2
   } bht_src_e;

   // Training rule: fresh entries start weak, trained ones saturate.
   function automatic bht_entry_t bht_train(bht_entry_t cur, logic taken);
      bht_entry_t nxt;
      nxt.vld = 1'b1;
      if (!cur.vld) begin
         nxt.ctr = taken ? 2'd2 : 2'd1;
      end else if (taken) begin
         nxt.ctr = (cur.ctr == 2'd3) ? 2'd3 : cur.ctr + 2'd1;
      end else begin
         nxt.ctr = (cur.ctr == 2'd0) ? 2'd0 : cur.ctr - 2'd1;
      end
      return nxt;
   endfunction

endpackage

// File: rtl/bht_sram_2r1w.sv
// Behavioural synchronous RAM: NRD registered read ports, one write port.
// A read on the same edge as a write to the same word returns the old word.
module bht_sram_2r1w #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned WIDTH = 3,
   parameter int unsigned NRD   = 2,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic                      clk_i,
   input  logic                      we_i,
   input  logic [AW-1:0]             waddr_i,
   input  logic [WIDTH-1:0]          wdata_i,
   input  logic [NRD-1:0][AW-1:0]    raddr_i,
   output logic [NRD-1:0][WIDTH-1:0] rdata_o
);

   logic [WIDTH-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      logic [WIDTH-1:0] rd_q;
      always_ff @(posedge clk_i) begin
         rd_q <= mem_q[raddr_i[g]];
      end
      assign rdata_o[g] = rd_q;
   end

endmodule

// File: rtl/bht_init_sweep.sv
// Post-reset clearing sequencer: one table index per cycle.
module bht_init_sweep #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   output logic          we_o,
   output logic [AW-1:0] idx_o,
   output logic          done_o
);

   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [AW-1:0] cnt_q;
   logic          busy_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == LAST_IDX) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign we_o   = busy_q;
   assign idx_o  = cnt_q;
   assign done_o = !busy_q;

endmodule

// File: rtl/bht_upd_pipe.sv
// Read-modify-write for updates: the RAM read fires on the strobe edge, the
// trained entry is formed in the next cycle and written at the end of it.
module bht_upd_pipe
   import bht_sync_pkg::*;
#(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fire_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             taken_i,
   input  bht_entry_t       ram_rd_i,
   output logic             wb_valid_o,
   output logic [IDX_W-1:0] wb_idx_o,
   output bht_entry_t       wb_entry_o,
   output logic             aux_valid_o,
   output logic [IDX_W-1:0] aux_idx_o,
   output bht_entry_t       aux_entry_o
);

   logic             s1_valid_q;
   logic [IDX_W-1:0] s1_idx_q;
   logic             s1_taken_q;
   logic             aux_valid_q;
   logic [IDX_W-1:0] aux_idx_q;
   bht_entry_t       aux_entry_q;
   bht_entry_t       base;
   bht_entry_t       trained;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_valid_q <= 1'b0;
         s1_idx_q   <= '0;
         s1_taken_q <= 1'b0;
      end else begin
         s1_valid_q <= fire_i;
         s1_idx_q   <= idx_i;
         s1_taken_q <= taken_i;
      end
   end

   // The RAM read of this entry happened on the edge that wrote the previous
   // write-back, so a write to the same index is only seen through aux.
   always_comb begin
      base = ram_rd_i;
      if (aux_valid_q && (aux_idx_q == s1_idx_q)) begin
         base = aux_entry_q;
      end
      trained = bht_train(base, s1_taken_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         aux_valid_q <= 1'b0;
         aux_idx_q   <= '0;
         aux_entry_q <= '0;
      end else if (s1_valid_q) begin
         aux_valid_q <= 1'b1;
         aux_idx_q   <= s1_idx_q;
         aux_entry_q <= trained;
      end
   end

   assign wb_valid_o  = s1_valid_q;
   assign wb_idx_o    = s1_idx_q;
   assign wb_entry_o  = trained;
   assign aux_valid_o = aux_valid_q;
   assign aux_idx_o   = aux_idx_q;
   assign aux_entry_o = aux_entry_q;

endmodule

// File: rtl/bht_sync_ram.sv
module bht_sync_ram
   import bht_sync_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned NUM_ENTRIES = 64,
   parameter int unsigned ALIGN_LSB   = 1,
   localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] lookup_addr_i,
   output logic              pred_valid_o,
   output logic              pred_taken_o,
   input  logic              upd_valid_i,
   input  logic [ADDR_W-1:0] upd_addr_i,
   input  logic              upd_taken_i
);

   localparam int unsigned RD_LKP = 0;
   localparam int unsigned RD_UPD = 1;

   // Elaboration-time parameter checks.
   if (NUM_ENTRIES < 2 || (1 << IDX_W) != NUM_ENTRIES) begin : g_bad_depth
      initial $fatal(1, "NUM_ENTRIES must be a power of two, at least 2");
   end
   if (ALIGN_LSB + IDX_W > ADDR_W) begin : g_bad_index
      initial $fatal(1, "index field does not fit in ADDR_W");
   end

   logic [IDX_W-1:0] lkp_idx;
   logic [IDX_W-1:0] upd_idx;
   assign lkp_idx = lookup_addr_i[ALIGN_LSB +: IDX_W];
   assign upd_idx = upd_addr_i[ALIGN_LSB +: IDX_W];

   // Clearing sweep.
   logic             sweep_we;
   logic [IDX_W-1:0] sweep_idx;
   logic             sweep_done;

   bht_init_sweep #(.DEPTH(NUM_ENTRIES)) sweep_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_o   (sweep_we),
      .idx_o  (sweep_idx),
      .done_o (sweep_done)
   );

   // Update read-modify-write.
   logic                               upd_fire;
   logic [1:0][IDX_W-1:0]              rd_addr;
   logic [1:0][BHT_ENTRY_W-1:0]        rd_data;
   logic                               wb_valid;
   logic [IDX_W-1:0]                   wb_idx;
   bht_entry_t                         wb_entry;
   logic                               aux_valid;
   logic [IDX_W-1:0]                   aux_idx;
   bht_entry_t                         aux_entry;

   assign upd_fire = upd_valid_i && sweep_done;

   bht_upd_pipe #(.IDX_W(IDX_W)) upd_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fire_i      (upd_fire),
      .idx_i       (upd_idx),
      .taken_i     (upd_taken_i),
      .ram_rd_i    (bht_entry_t'(rd_data[RD_UPD])),
      .wb_valid_o  (wb_valid),
      .wb_idx_o    (wb_idx),
      .wb_entry_o  (wb_entry),
      .aux_valid_o (aux_valid),
      .aux_idx_o   (aux_idx),
      .aux_entry_o (aux_entry)
   );

   // Single write port, shared by the sweep and the update write-back.
   logic                   wr_en;
   logic [IDX_W-1:0]       wr_idx;
   bht_entry_t             wr_data;

   always_comb begin
      wr_en  = sweep_we || wb_valid;
      wr_idx = sweep_we ? sweep_idx : wb_idx;
      wr_data = sweep_we ? bht_entry_t'('0) : wb_entry;
   end

   assign rd_addr[RD_LKP] = lkp_idx;
   assign rd_addr[RD_UPD] = upd_idx;

   bht_sram_2r1w #(
      .DEPTH (NUM_ENTRIES),
      .WIDTH (BHT_ENTRY_W),
      .NRD   (2)
   ) ram_i (
      .clk_i   (clk_i),
      .we_i    (wr_en),
      .waddr_i (wr_idx),
      .wdata_i (wr_data),
      .raddr_i (rd_addr),
      .rdata_o (rd_data)
   );

   // Lookup stage: index and readiness registered alongside the RAM read.
   logic [IDX_W-1:0] lkp_idx_q;
   logic             lkp_ok_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lkp_idx_q <= '0;
         lkp_ok_q  <= 1'b0;
      end else begin
         lkp_idx_q <= lkp_idx;
         lkp_ok_q  <= sweep_done;
      end
   end

   // Freshest copy by update age: same edge, one edge back, older.
   bht_src_e   pred_src;
   bht_entry_t pred_entry;

   always_comb begin
      if (wb_valid && (wb_idx == lkp_idx_q)) begin
         pred_src = SRC_UPD;
      end else if (aux_valid && (aux_idx == lkp_idx_q)) begin
         pred_src = SRC_AUX;
      end else begin
         pred_src = SRC_RAM;
      end
      unique case (pred_src)
         SRC_UPD: pred_entry = wb_entry;
         SRC_AUX: pred_entry = aux_entry;
         default: pred_entry = bht_entry_t'(rd_data[RD_LKP]);
      endcase
   end

   assign pred_valid_o = lkp_ok_q && pred_entry.vld;
   assign pred_taken_o = lkp_ok_q && pred_entry.vld && pred_entry.ctr[1];

endmodule

// File: rtl/bht_sync_ram_chk.sv
module bht_sync_ram_chk #(
   parameter int unsigned IDX_W = 6
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             upd_valid_i,
   input logic [IDX_W-1:0] upd_idx,
   input logic             sweep_done,
   input logic             sweep_we,
   input logic             wb_valid,
   input logic [IDX_W-1:0] wb_idx,
   input logic             wr_vld,
   input logic [1:0]       wr_ctr,
   input logic             aux_valid,
   input logic [IDX_W-1:0] aux_idx,
   input logic             aux_vld,
   input logic [1:0]       aux_ctr,
   input logic             pred_valid_o
);

   AST_QUIET_IN_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sweep_done |-> !pred_valid_o);                                          // R2
   AST_SWEEP_DROPS_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sweep_done |=> !wb_valid);                                              // R2
   AST_WR_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sweep_we && wb_valid));                                                // R2
   AST_SWEEP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sweep_we |-> (!wr_vld && wr_ctr == 2'd0));                               // R2
   AST_WB_ONE_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_valid_i && sweep_done) |=> (wb_valid && wb_idx == $past(upd_idx))); // R11
   AST_WB_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_valid |-> wr_vld);                                                    // R4
   AST_AUX_FOLLOWS_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_valid |=> (aux_valid && aux_idx == $past(wb_idx) && aux_vld
                    && aux_ctr == $past(wr_ctr)));                             // R8
   AST_B2B_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_valid && $past(wb_valid) && wb_idx == $past(wb_idx))
         |-> ((wr_ctr - $past(wr_ctr)) != 2'd2));                              // R10

endmodule

bind bht_sync_ram bht_sync_ram_chk #(.IDX_W(IDX_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .upd_valid_i  (upd_valid_i),
   .upd_idx      (upd_idx),
   .sweep_done   (sweep_done),
   .sweep_we     (sweep_we),
   .wb_valid     (wb_valid),
   .wb_idx       (wb_idx),
   .wr_vld       (wr_data.vld),
   .wr_ctr       (wr_data.ctr),
   .aux_valid    (aux_valid),
   .aux_idx      (aux_idx),
   .aux_vld      (aux_entry.vld),
   .aux_ctr      (aux_entry.ctr),
   .pred_valid_o (pred_valid_o)
);

// File: tb/bht_sync_ram_tb_top.sv
module bht_sync_ram_tb_top;

   localparam int AW = 32;
   localparam int N  = 64;
   localparam int AL = 1;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] lookup_addr = '0;
   logic          upd_v = 1'b0;
   logic [AW-1:0] upd_a = '0;
   logic          upd_t = 1'b0;
   logic          pred_valid_o;
   logic          pred_taken_o;

   always #5 clk = ~clk;

   bht_sync_ram #(.ADDR_W(AW), .NUM_ENTRIES(N), .ALIGN_LSB(AL)) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .lookup_addr_i (lookup_addr),
      .pred_valid_o  (pred_valid_o),
      .pred_taken_o  (pred_taken_o),
      .upd_valid_i   (upd_v),
      .upd_addr_i    (upd_a),
      .upd_taken_i   (upd_t)
   );

   int   n_chk = 0;
   int   n_bad = 0;
   int   edge_n = 0;
   bit   finished = 0;
   bit   ref_vld [N];
   logic [1:0] ref_ctr [N];

   function automatic int idx_of(logic [AW-1:0] a);
      return int'((a >> AL) & (N - 1));
   endfunction

   function automatic logic [AW-1:0] mk_addr(int idx);
      logic [AW-1:0] a;
      a = $urandom;
      a[AL +: IW] = IW'(idx);
      return a;
   endfunction

   function automatic void ref_train(int i, bit tk);
      if (!ref_vld[i]) ref_ctr[i] = tk ? 2'd2 : 2'd1;
      else if (tk) ref_ctr[i] = (ref_ctr[i] == 2'd3) ? 2'd3 : ref_ctr[i] + 2'd1;
      else ref_ctr[i] = (ref_ctr[i] == 2'd0) ? 2'd0 : ref_ctr[i] - 2'd1;
      ref_vld[i] = 1'b1;
   endfunction

   task automatic check(string req, bit ev, bit et);
      n_chk++;
      if (pred_valid_o !== ev || pred_taken_o !== et) begin
         n_bad++;
         $display("FAIL %s: actual valid=%0b taken=%0b, expected valid=%0b taken=%0b",
                  req, pred_valid_o, pred_taken_o, ev, et);
      end
   endtask

   // One cycle: drive at negedge, model at posedge, sample at next negedge.
   task automatic cyc(logic [AW-1:0] la, bit uv, logic [AW-1:0] ua, bit ut, string req);
      bit ev, et;
      lookup_addr = la; upd_v = uv; upd_a = ua; upd_t = ut;
      @(posedge clk);
      edge_n++;
      if (uv && edge_n > N) ref_train(idx_of(ua), ut);
      ev = (edge_n > N) && ref_vld[idx_of(la)];
      et = ev && ref_ctr[idx_of(la)][1];
      @(negedge clk);
      check(req, ev, et);
   endtask

   task automatic look(int idx, string req);
      cyc(mk_addr(idx), 1'b0, '0, 1'b0, req);
   endtask

   task automatic upd(int li, int ui, bit tk, string req);
      cyc(mk_addr(li), 1'b1, mk_addr(ui), tk, req);
   endtask

   initial begin
      void'($urandom(32'h1bad5eed));
      for (int i = 0; i < N; i++) begin
         ref_vld[i] = 1'b0;
         ref_ctr[i] = 2'd0;
      end
      repeat (3) @(negedge clk);
      check("R2 reset", 1'b0, 1'b0);
      rst_n = 1'b1;

      // R2: sweep window ignores updates and reports invalid.
      for (int i = 0; i < N; i++) upd(i, i, 1'b1, "R2 sweep");
      // R2: every entry invalid after the sweep.
      for (int i = 0; i < N; i++) look(i, "R2 cleared");

      // R4: weak initial training.
      upd(3, 3, 1'b1, "R7 first taken");
      look(3, "R4 init taken");
      upd(4, 4, 1'b0, "R7 first not-taken");
      look(4, "R4 init not-taken");
      upd(9, 4, 1'b1, "R4 train");
      look(4, "R4 weak to taken");

      // R7/R8/R9: lookups at age 0, 1, 2 and more on entry 10.
      upd(10, 10, 1'b0, "R7 age0");
      look(10, "R8 age1");
      look(10, "R9 age2");
      look(10, "R9 age3");
      upd(10, 10, 1'b1, "R7 age0 flip");
      look(10, "R8 age1 flip");
      look(10, "R9 age2 flip");
      upd(11, 10, 1'b0, "R8 aux other idx");
      look(10, "R8 age1 after other");
      upd(10, 11, 1'b1, "R8 aux vs new idx");
      look(10, "R9 age2 ram");

      // R10 + R5: back-to-back updates to one entry, saturation both ends.
      for (int k = 0; k < 5; k++) upd(20, 20, 1'b1, "R10 b2b taken");
      look(20, "R5 sat high");
      upd(20, 20, 1'b0, "R5 down from 3");
      upd(20, 20, 1'b0, "R10 down to 1");
      look(20, "R5 at 1");
      for (int k = 0; k < 4; k++) upd(20, 20, 1'b0, "R10 b2b not-taken");
      upd(20, 20, 1'b1, "R5 up from 0");
      look(20, "R6 ctr1 not taken");
      upd(20, 20, 1'b1, "R6 ctr2 taken");

      // R1: aliasing by index field only.
      cyc(mk_addr(30), 1'b1, mk_addr(30) ^ 32'h8000_0001, 1'b1, "R1 alias upd");
      look(30, "R1 alias hit");
      look(31, "R1 neighbour untouched");
      look(29, "R1 neighbour untouched");

      // R3: constrained random mix with frequent collisions.
      for (int k = 0; k < 4000; k++) begin
         int li, ui;
         li = ($urandom % 8 == 0) ? int'($urandom % N) : int'($urandom % 4);
         ui = ($urandom % 8 == 0) ? int'($urandom % N) : int'($urandom % 4);
         cyc(mk_addr(li), ($urandom % 10) < 6, mk_addr(ui), $urandom % 2 == 1, "R3 random");
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual still running, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule